// File: doc/BRIEF.md
# Masked PC Breakpoint Comparator

This block watches the address of each executing instruction and flags a breakpoint hit when that address falls inside, or optionally outside, a programmable set of addresses. The set is made of four compare registers. Compare register 0 is paired with a mask register: every mask bit that is set removes the matching address bit from the compare. Compare registers 1 to 3 always compare all bits, and each one joins the set only when its own valid bit is set.

A core presents its program counter together with a strobe. One cycle later the block returns a single-cycle hit for that strobe when the global enable is on and the PC meets the selected sense. A simple address/data/write-enable port programs the compare registers, the mask and a control word.

Top module: `pc_bkpt_cmp`

## Requirements
- R1: After reset, hit is 0, and all compare registers, the mask and the control word are 0. Because of this the function is disabled until software sets the enable bit.
- R2: Compare register 0 matches when every PC bit whose mask bit is 0 equals the stored bit. PC bits whose mask bit is 1 are ignored. Bits [1:0] take part like any other bit. Compare register 0 always takes part in the set.
- R3: Compare registers 1 to 3 match only on exact equality of all 32 bits, and only while their valid bit is set. When the valid bit is clear, the register never matches.
- R4: While the enable bit (control bit 0) is 0, hit stays 0 for every PC and every strobe.
- R5: With invert (control bit 1) at 0, a strobed PC gives a hit when it matches at least one register in the set.
- R6: With invert at 1, a strobed PC gives a hit when it matches no register in the set. If no valid bit is set, every strobed PC that misses masked compare register 0 gives a hit.
- R7: Hit is registered. It is 1 in the cycle after a qualifying strobe, for that one cycle only. It is 0 after any cycle with no strobe. Back-to-back strobes give one independent result each.
- R8: On a write-port select, values 0 to 3 write compare registers 0 to 3, 4 writes the mask, and 5 writes the control word. The control word layout is: bit 0 enable, bit 1 invert, bits 2, 3 and 4 the valid bits of registers 1, 2 and 3. Selects 6 and 7 change nothing. A strobe in the same cycle as a write is judged against the values held before that write.
- R9: The mask acts on compare register 0 only. Compare registers 1 to 3 ignore it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| pc | input | 32 | Executing instruction address |
| pc_vld | input | 1 | PC strobe |
| hit | output | 1 | Breakpoint hit, one cycle after the strobe |

## Verification
Every piece of state in this block feeds the hit output within one cycle. A flipped mask bit, a stuck valid bit, or a wrong enable or invert setting therefore shows up as a wrong hit level on the very next strobe whose PC exercises that bit. The bench models the registers on its own and predicts the hit for every cycle, so any such divergence is seen one cycle after the strobe that exposes it. Directed patterns target the masked low bits, the valid gating and the inverted empty set, because random PCs rarely reach those cases.

// File: rtl/pc_bkpt_cmp.sv
module pc_bkpt_cmp #(
  parameter int ADDR_W  = 32,
  parameter int NUM_CMP = 4,
  localparam int SEL_W  = $clog2(NUM_CMP + 2),
  localparam int CTRL_W = NUM_CMP + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] pc,
  input  logic              pc_vld,
  output logic              hit
);

  logic [ADDR_W-1:0] cmp_q [NUM_CMP];
  logic [ADDR_W-1:0] mask_q;
  logic [CTRL_W-1:0] ctrl_q;

  logic                 en_q;
  logic                 inv_q;
  logic [NUM_CMP-1:1]   vld_q;
  logic [NUM_CMP-1:0]   match;
  logic                 in_region;

  assign en_q  = ctrl_q[0];
  assign inv_q = ctrl_q[1];
  assign vld_q = ctrl_q[CTRL_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CMP; k++) cmp_q[k] <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_CMP; k++)
        if (wr_sel == SEL_W'(k)) cmp_q[k] <= wr_data;
      if (wr_sel == SEL_W'(NUM_CMP))     mask_q <= wr_data;
      if (wr_sel == SEL_W'(NUM_CMP + 1)) ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  assign match[0] = ((pc ^ cmp_q[0]) & ~mask_q) == '0;

  for (genvar k = 1; k < NUM_CMP; k++) begin : g_exact
    assign match[k] = vld_q[k] && (pc == cmp_q[k]);
  end

  assign in_region = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= pc_vld && en_q && (in_region ^ inv_q);
  end

endmodule

module pc_bkpt_cmp_chk #(
  parameter int W = 32,
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pc,
  input logic         pc_vld,
  input logic         hit,
  input logic         en,
  input logic         inv,
  input logic [N-1:1] vld,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] cmp1,
  input logic [W-1:0] mask
);

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_vld |=> !hit); // R7

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !hit); // R4

  AST_MASKED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_vld && en && !inv && (((pc ^ cmp0) & ~mask) == '0)) |=> hit); // R2

  AST_EXACT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_vld && en && !inv && vld[1] && pc == cmp1) |=> hit); // R3

  AST_INVERT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_vld && en && inv && vld == '0 && (((pc ^ cmp0) & ~mask) != '0)) |=> hit); // R6

  AST_INVERT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_vld && inv && (((pc ^ cmp0) & ~mask) == '0)) |=> !hit); // R6

endmodule

bind pc_bkpt_cmp pc_bkpt_cmp_chk #(.W(ADDR_W), .N(NUM_CMP)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pc     (pc),
  .pc_vld (pc_vld),
  .hit    (hit),
  .en     (en_q),
  .inv    (inv_q),
  .vld    (vld_q),
  .cmp0   (cmp_q[0]),
  .cmp1   (cmp_q[1]),
  .mask   (mask_q)
);

// File: tb/pc_bkpt_cmp_test.sv
module pc_bkpt_cmp_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pc = '0;
  logic        pc_vld = 1'b0;
  logic        hit;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_cmp [4];
  logic [31:0] m_mask;
  logic [4:0]  m_ctrl;
  bit          pend_exp;
  string       pend_tag;

  always #5 clk = ~clk;

  pc_bkpt_cmp uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pc(pc), .pc_vld(pc_vld), .hit(hit)
  );

  function automatic bit exp_hit(input logic [31:0] p, input bit v);
    bit in_set;
    in_set = ((p ^ m_cmp[0]) & ~m_mask) == 32'h0;
    for (int k = 1; k < 4; k++)
      if (m_ctrl[k+1] && p == m_cmp[k]) in_set = 1'b1;
    return v && m_ctrl[0] && (in_set ^ m_ctrl[1]);
  endfunction

  task automatic check(input bit exp, input string tag);
    checks++;
    if (hit !== exp) begin
      fails++;
      $display("FAIL %s: hit=%b expected=%b at %0t", tag, hit, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] sel, input logic [31:0] d,
                     input bit v, input logic [31:0] p, input string tag);
    @(negedge clk);
    check(pend_exp, pend_tag);
    wr_en = we; wr_sel = sel; wr_data = d; pc_vld = v; pc = p;
    pend_exp = exp_hit(p, v);
    pend_tag = tag;
    if (we) begin
      if (sel < 3'd4)       m_cmp[sel[1:0]] = d;
      else if (sel == 3'd4) m_mask = d;
      else if (sel == 3'd5) m_ctrl = d[4:0];
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d, input string tag);
    cyc(1'b1, sel, d, 1'b0, 32'h0, tag);
  endtask

  task automatic strobe(input logic [31:0] p, input string tag);
    cyc(1'b0, 3'd0, 32'h0, 1'b1, p, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] p;
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) m_cmp[k] = '0;
    m_mask = '0; m_ctrl = '0;
    pend_exp = 1'b0; pend_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset hit");

    strobe(32'h0, "R1 disabled after reset");
    idle("R1");

    wr(3'd0, 32'h1000_0040, "R8");
    strobe(32'h1000_0040, "R4 match but disabled");
    idle("R4");

    wr(3'd5, 32'h0000_0001, "R8");
    strobe(32'h1000_0040, "R5 exact reg0");
    strobe(32'h1000_0041, "R2 bit0 compared");
    wr(3'd4, 32'h0000_00FF, "R8");
    strobe(32'h1000_00A3, "R2 masked low bits");
    strobe(32'h1000_0140, "R2 unmasked bit8");
    idle("R7 no strobe");

    wr(3'd1, 32'h2000_0000, "R8");
    strobe(32'h2000_0000, "R3 valid clear");
    wr(3'd5, 32'h0000_0005, "R8");
    strobe(32'h2000_0000, "R3 valid set");
    strobe(32'h2000_0001, "R9 reg1 ignores mask");
    wr(3'd2, 32'h3000_0010, "R8");
    wr(3'd5, 32'h0000_0009, "R8");
    strobe(32'h3000_0010, "R3 reg2 valid");
    strobe(32'h2000_0000, "R3 reg1 now invalid");
    strobe(32'h3000_0011, "R9 reg2 ignores mask");

    wr(3'd5, 32'h0000_000B, "R8");
    strobe(32'h3000_0010, "R6 inside inverted");
    strobe(32'h4000_0000, "R6 outside inverted");
    strobe(32'h1000_0077, "R6 masked reg0 inverted");

    wr(3'd6, 32'hFFFF_FFFF, "R8");
    wr(3'd7, 32'hFFFF_FFFF, "R8");
    strobe(32'h4000_0000, "R8 unused selects");
    strobe(32'h3000_0010, "R8 unused selects");

    wr(3'd4, 32'h0, "R8");
    wr(3'd0, 32'hFFFF_FFFC, "R8");
    wr(3'd5, 32'h0000_0003, "R8");
    for (int i = 0; i < 40; i++) begin
      p = $urandom;
      if (p == 32'hFFFF_FFFC) p = 32'h0;
      strobe(p, "R6 empty set inverted");
    end
    strobe(32'hFFFF_FFFC, "R6 reg0 hit inverted");

    wr(3'd5, 32'h0000_0001, "R8");
    cyc(1'b1, 3'd5, 32'h0, 1'b1, 32'hFFFF_FFFC, "R8 write with strobe");
    strobe(32'hFFFF_FFFC, "R4 after disable");
    wr(3'd5, 32'h0000_0001, "R8");
    strobe(32'hFFFF_FFFC, "R7 back to back");
    strobe(32'hFFFF_FFFC, "R7 back to back");
    idle("R7 single cycle");

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) begin
        logic [2:0]  s;
        logic [31:0] d;
        s = 3'($urandom_range(0, 7));
        d = (s == 3'd4) ? ($urandom & $urandom & $urandom) : $urandom;
        wr(s, d, "R8 random write");
      end else if (r < 3) begin
        idle("R7 random idle");
      end else begin
        int k;
        k = $urandom_range(0, 4);
        if (k == 4) p = $urandom;
        else if (k == 0) p = m_cmp[0] ^ ($urandom & m_mask);
        else p = m_cmp[k];
        if ($urandom_range(0, 7) == 0) p = p ^ 32'h1;
        strobe(p, "R5 random strobe");
      end
    end
    idle("R7");
    @(negedge clk);
    check(pend_exp, pend_tag);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule